// File: doc/BRIEF.md
# Configurable GPIO Function Multiplexer

This block sits between eight general-purpose pads of a clock-management controller and the logic behind them. Each pad can be an input or an output. As an input it can act as an output-enable control, as a reference clock-select bit, or as a plain readable bit. As an output it can carry a live alarm (loss of signal, loss of lock, holdover) or a value written by software. The block also forms the final enable and the high-impedance control for each of the eight clock output drivers.

A two-state controller sets the operating mode. In `ST_BOOT`, entered at reset and whenever `config_loaded` is sampled low, every pad is an input and acts as the output-enable for the clock output with the same index. The transition `BOOT_TO_LIVE` fires on the first clock edge that samples `config_loaded` high. In `ST_LIVE`, the per-pin direction and function fields from the configuration registers take effect. The transition `LIVE_TO_BOOT` fires on the first edge that samples `config_loaded` low. Pad inputs pass through a shared two-flop synchronizer before any use.

Top module: `gpio_fn_mux`

## Requirements
- R1: In `ST_BOOT`, every pad is an input (`pad_oe` = 0, `pad_out` = 0), `gpi` and both clock-select outputs read 0, and each synchronized pad n acts as output-enable n.
- R2: The state moves to `ST_LIVE` on the edge that samples `config_loaded` = 1, and returns to `ST_BOOT` on the edge that samples it 0.
- R3: `clk_out_en[n]` = `out_en_reg[n]` AND the output-enable level for n; `clk_out_hiz[n]` is its complement.
- R4: In `ST_LIVE`, the output-enable for n is taken from pad n only when pin n is an input with function code 00. Otherwise it reads as asserted, and `out_en_reg[n]` alone decides.
- R5: An output pin with function code 00 or 01 carries status. Pins 7 down to 0 carry los[3], los[2], los[1], hold[1], lol[1], los[0], hold[0], lol[0], with no register stage in between.
- R6: An output pin with function code 10 or 11 drives `gpo_val[n]`.
- R7: An input pin with function code 01 supplies clock-select bits: pin 7 gives `csel1[1]`, pin 6 `csel0[1]`, pin 3 `csel1[0]`, pin 2 `csel0[0]`. Clock-select bits without such a pin read 0, and pins 5, 4, 1 and 0 in this code drive nothing.
- R8: An input pin with function code 10 or 11 is readable on `gpi[n]`. Every other pin reads 0 there.
- R9: A pad input change appears at the outputs after exactly two rising clock edges.
- R10: In `ST_LIVE`, `pad_oe` equals `pin_dir` (1 = output), and an input pin's `pad_out` is 0.
- R11: While `rst_n` is low, the state is `ST_BOOT` and the synchronizer holds 0, so every clock output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| config_loaded | input | 1 | Register configuration is valid |
| pin_dir | input | 8 | Per-pin direction, 1 = output |
| pin_fn | input | 16 | Per-pin function code, bits [2n+1:2n] for pin n |
| gpo_val | input | 8 | Register values for general-purpose outputs |
| out_en_reg | input | 8 | Register enable bit per clock output |
| los | input | 4 | Loss-of-signal alarms per reference input |
| lol | input | 2 | Loss-of-lock alarms per loop |
| hold | input | 2 | Holdover alarms per loop |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad driver enables |
| gpi | output | 8 | Synchronized general-purpose input readback |
| csel0 | output | 2 | Clock-select bit 0 per loop |
| csel1 | output | 2 | Clock-select bit 1 per loop |
| clk_out_en | output | 8 | Final enable per clock output |
| clk_out_hiz | output | 8 | High-impedance control per clock output driver |

## Verification
The assertions assume that `config_loaded` and the configuration fields change only on the register clock and are not unknown after reset. They also assume that the alarm inputs are already in the register domain. The bench drives every input at the falling edge and leaves each setting in place for at least three rising edges before it samples. It changes raw pads only between vectors, which fits the two-stage synchronizer the block assumes.

// File: rtl/gpio_fn_pkg.sv
package gpio_fn_pkg;
    localparam int PIN_COUNT = 8;
    localparam int FN_BITS   = 2;
    localparam int LOOP_COUNT = 2;

    typedef enum logic [0:0] {
        ST_BOOT = 1'b0,
        ST_LIVE = 1'b1
    } mux_state_e;

    typedef enum logic [1:0] {
        FN_FIXED  = 2'b00,
        FN_CSEL   = 2'b01,
        FN_GP     = 2'b10,
        FN_GP_ALT = 2'b11
    } pin_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_mode_fsm.sv
module gpio_mode_fsm
    import gpio_fn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic config_loaded,
    output logic live
);
    mux_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (config_loaded)  state_d = ST_LIVE;
            ST_LIVE: if (!config_loaded) state_d = ST_BOOT;
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        live = 1'b0;
        unique case (state_q)
            ST_BOOT: live = 1'b0;
            ST_LIVE: live = 1'b1;
            default: live = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_fn_pkg::*;
(
    input  logic                live,
    input  logic                dir_out,
    input  logic [FN_BITS-1:0]  fn_code,
    input  logic                pad_sync,
    input  logic                status_bit,
    input  logic                gpo_bit,
    output logic                drv_en,
    output logic                drv_val,
    output logic                gpi_bit,
    output logic                oe_level,
    output logic                csel_bit
);
    pin_fn_e fn;
    assign fn = pin_fn_e'(fn_code);

    always_comb begin
        drv_en   = 1'b0;
        drv_val  = 1'b0;
        gpi_bit  = 1'b0;
        oe_level = 1'b1;
        csel_bit = 1'b0;
        if (!live) begin
            oe_level = pad_sync;
        end else if (dir_out) begin
            drv_en = 1'b1;
            unique case (fn)
                FN_FIXED, FN_CSEL: drv_val = status_bit;
                FN_GP, FN_GP_ALT:  drv_val = gpo_bit;
                default:           drv_val = 1'b0;
            endcase
        end else begin
            unique case (fn)
                FN_FIXED:         oe_level = pad_sync;
                FN_CSEL:          csel_bit = pad_sync;
                FN_GP, FN_GP_ALT: gpi_bit  = pad_sync;
                default:          gpi_bit  = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_fn_mux.sv
module gpio_fn_mux
    import gpio_fn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          config_loaded,
    input  logic [PIN_COUNT-1:0]          pin_dir,
    input  logic [PIN_COUNT*FN_BITS-1:0]  pin_fn,
    input  logic [PIN_COUNT-1:0]          gpo_val,
    input  logic [PIN_COUNT-1:0]          out_en_reg,
    input  logic [3:0]                    los,
    input  logic [LOOP_COUNT-1:0]         lol,
    input  logic [LOOP_COUNT-1:0]         hold,
    input  logic [PIN_COUNT-1:0]          pad_in,
    output logic [PIN_COUNT-1:0]          pad_out,
    output logic [PIN_COUNT-1:0]          pad_oe,
    output logic [PIN_COUNT-1:0]          gpi,
    output logic [LOOP_COUNT-1:0]         csel0,
    output logic [LOOP_COUNT-1:0]         csel1,
    output logic [PIN_COUNT-1:0]          clk_out_en,
    output logic [PIN_COUNT-1:0]          clk_out_hiz
);
    logic                 live;
    logic [PIN_COUNT-1:0] pad_sync;
    logic [PIN_COUNT-1:0] status_vec;
    logic [PIN_COUNT-1:0] oe_vec;
    logic [PIN_COUNT-1:0] csel_raw;

    gpio_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .config_loaded (config_loaded),
        .live          (live)
    );

    gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pad_sync)
    );

    // fixed pin-to-alarm routing, pin 7 first
    assign status_vec = {los[3], los[2], los[1], hold[1], lol[1], los[0], hold[0], lol[0]};

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        gpio_pin_slice u_slice (
            .live       (live),
            .dir_out    (pin_dir[p]),
            .fn_code    (pin_fn[p*FN_BITS +: FN_BITS]),
            .pad_sync   (pad_sync[p]),
            .status_bit (status_vec[p]),
            .gpo_bit    (gpo_val[p]),
            .drv_en     (pad_oe[p]),
            .drv_val    (pad_out[p]),
            .gpi_bit    (gpi[p]),
            .oe_level   (oe_vec[p]),
            .csel_bit   (csel_raw[p])
        );
    end

    // only pins 7, 6, 3 and 2 feed clock-select bits
    assign csel1 = {csel_raw[7], csel_raw[3]};
    assign csel0 = {csel_raw[6], csel_raw[2]};

    assign clk_out_en  = out_en_reg & oe_vec;
    assign clk_out_hiz = ~clk_out_en;
endmodule

// File: rtl/gpio_fn_mux_chk.sv
module gpio_fn_mux_chk
    import gpio_fn_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          config_loaded,
    input logic [PIN_COUNT-1:0]          pin_dir,
    input logic [PIN_COUNT-1:0]          out_en_reg,
    input logic [PIN_COUNT-1:0]          pad_out,
    input logic [PIN_COUNT-1:0]          pad_oe,
    input logic [PIN_COUNT-1:0]          gpi,
    input logic [LOOP_COUNT-1:0]         csel0,
    input logic [LOOP_COUNT-1:0]         csel1,
    input logic [PIN_COUNT-1:0]          clk_out_en,
    input logic [PIN_COUNT-1:0]          clk_out_hiz
);
    AST_EN_NEEDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out_en & ~out_en_reg) == '0); // R3

    AST_HIZ_OPPOSES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out_en ^ clk_out_hiz) == '1); // R3

    AST_BOOT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(config_loaded) || !$past(rst_n)) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_BOOT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(config_loaded) || !$past(rst_n)) |-> (gpi == '0 && csel0 == '0 && csel1 == '0)); // R1

    AST_LIVE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(config_loaded) && $past(rst_n)) |-> (pad_oe == pin_dir)); // R2

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R10
endmodule

bind gpio_fn_mux gpio_fn_mux_chk u_chk (.*);

// File: tb/gpio_fn_mux_test.sv
`timescale 1ns/1ps
module gpio_fn_mux_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        config_loaded = 1'b0;
    logic [7:0]  pin_dir = '0;
    logic [15:0] pin_fn = '0;
    logic [7:0]  gpo_val = '0;
    logic [7:0]  out_en_reg = '0;
    logic [3:0]  los = '0;
    logic [1:0]  lol = '0;
    logic [1:0]  hold = '0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, gpi, clk_out_en, clk_out_hiz;
    logic [1:0]  csel0, csel1;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_fn_mux uut (.*);

    typedef struct packed {
        logic        cfg;
        logic [7:0]  dir;
        logic [15:0] fn;
        logic [7:0]  gpo;
        logic [7:0]  oereg;
        logic [7:0]  pad;
        logic [3:0]  los;
        logic [1:0]  lol;
        logic [1:0]  hold;
        logic [7:0]  e_oe;
        logic [7:0]  e_out;
        logic [7:0]  e_gpi;
        logic [1:0]  e_c0;
        logic [1:0]  e_c1;
        logic [7:0]  e_en;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'hFF, 16'hAAAA, 8'hFF, 8'hFF, 8'h5A, 4'h0, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00, 2'd0, 2'd0, 8'h5A},
        '{1'b0, 8'hFF, 16'hAAAA, 8'hFF, 8'h0F, 8'hFF, 4'h0, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00, 2'd0, 2'd0, 8'h0F},
        '{1'b1, 8'h00, 16'h0000, 8'h00, 8'hFF, 8'h3C, 4'h0, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00, 2'd0, 2'd0, 8'h3C},
        '{1'b1, 8'hFF, 16'h0000, 8'h00, 8'hA5, 8'h00, 4'hA, 2'd1, 2'd2, 8'hFF, 8'hB1, 8'h00, 2'd0, 2'd0, 8'hA5},
        '{1'b1, 8'hFF, 16'hAAAA, 8'h6C, 8'h33, 8'h00, 4'hA, 2'd1, 2'd2, 8'hFF, 8'h6C, 8'h00, 2'd0, 2'd0, 8'h33},
        '{1'b1, 8'h00, 16'h5555, 8'h00, 8'hFF, 8'hCC, 4'h0, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00, 2'd3, 2'd3, 8'hFF},
        '{1'b1, 8'h00, 16'h5555, 8'h00, 8'h0F, 8'h84, 4'h0, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1, 2'd2, 8'h0F},
        '{1'b1, 8'h00, 16'hAAAA, 8'h00, 8'hF0, 8'h96, 4'h0, 2'd0, 2'd0, 8'h00, 8'h00, 8'h96, 2'd0, 2'd0, 8'hF0},
        '{1'b1, 8'hF0, 16'hA009, 8'h80, 8'hFF, 8'h0A, 4'hA, 2'd1, 2'd2, 8'hF0, 8'hB0, 8'h02, 2'd0, 2'd0, 8'hFB},
        '{1'b0, 8'hFF, 16'hAAAA, 8'hFF, 8'hFF, 8'h81, 4'hA, 2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 2'd0, 2'd0, 8'h81}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:    return "R1 R3";
            2:       return "R2 R3";
            3:       return "R5 R4";
            4:       return "R6 R4";
            5, 6:    return "R7";
            7:       return "R8";
            8:       return "R10 R4";
            default: return "R2 R1";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_edges(int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state with pads high
        pad_in = 8'hFF; out_en_reg = 8'hFF; pin_dir = 8'hFF;
        wait_edges(3);
        check("R11 en", {56'd0, clk_out_en}, 64'h00);
        check("R11 hiz", {56'd0, clk_out_hiz}, 64'hFF);
        check("R11 pad_oe", {56'd0, pad_oe}, 64'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            config_loaded = VEC[i].cfg;
            pin_dir = VEC[i].dir;  pin_fn = VEC[i].fn;
            gpo_val = VEC[i].gpo;  out_en_reg = VEC[i].oereg;
            pad_in = VEC[i].pad;   los = VEC[i].los;
            lol = VEC[i].lol;      hold = VEC[i].hold;
            wait_edges(3);
            check(vec_tag(i),
                  {20'd0, pad_oe, pad_out, gpi, csel0, csel1, clk_out_en},
                  {20'd0, VEC[i].e_oe, VEC[i].e_out, VEC[i].e_gpi, VEC[i].e_c0, VEC[i].e_c1, VEC[i].e_en});
            check("R3 hiz", {56'd0, clk_out_hiz}, {56'd0, ~VEC[i].e_en});
        end

        // R2: entry into live takes exactly one edge
        config_loaded = 1'b0; pin_dir = 8'hFF; pin_fn = 16'hAAAA; gpo_val = 8'h00;
        wait_edges(2);
        config_loaded = 1'b1;
        #1 check("R2 before edge", {56'd0, pad_oe}, 64'h00);
        wait_edges(1);
        check("R2 after edge", {56'd0, pad_oe}, 64'hFF);
        config_loaded = 1'b0;
        wait_edges(1);
        check("R2 back to boot", {56'd0, pad_oe}, 64'h00);

        // R9: two-edge synchronizer latency on general-purpose inputs
        config_loaded = 1'b1; pin_dir = 8'h00; pin_fn = 16'hAAAA; pad_in = 8'h00;
        wait_edges(3);
        pad_in = 8'hE7;
        wait_edges(1);
        check("R9 one edge", {56'd0, gpi}, 64'h00);
        wait_edges(1);
        check("R9 two edges", {56'd0, gpi}, 64'hE7);

        // R5: status follows alarms with no register stage
        pin_dir = 8'hFF; pin_fn = 16'h0000; los = 4'h5; lol = 2'd2; hold = 2'd1;
        #1 check("R5 live status", {56'd0, pad_out}, 64'h4E);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule